// File: doc/BRIEF.md
# Shared-Wire Flag Decoder and Pause Controller

This block is the top-level sequencer of a device that sits with several others on one shared signal wire. A lower layer turns pulse trains into whole 8-bit flag bytes, command-block bytes and a strobe for the leading edge of every token. From these the block decides what the device does next. It can leave sleep on a wake event, take in a command block, hand a checked block to an execution engine, turn the wire around for a reply, park in idle or go back to sleep.

Every command block is checked against the fixed length of its opcode before anything runs. A pause command carries an optional 4-bit address that is compared with four fuse bits. A device whose address matches goes deaf to the wire. It leaves that state only when the watchdog expires, so the host can pick one device on the shared wire by pausing all the others.

Two counters bound the device's time awake. An inter-token timeout sends it back to sleep when the wire goes quiet. A watchdog started at wake forces sleep from any state.

Top module: `swfc_top`

## Requirements
- R1: While reset is held and after its release, the device is asleep. awake, idleMode, paused, execStart, txStart and txResult are 0, and statusCode is 0x00.
- R2: A wakeIn pulse while asleep makes awake 1 on the next cycle. At the same time statusCode becomes 0x11 and txResult becomes 0.
- R3: Four flag bytes are decoded in the ready state: 0x77 command, 0x88 transmit, 0xBB idle, 0xCC sleep. Any other flag byte changes no output. Flags are ignored in every other state.
- R4: Accepting a command flag clears statusCode to 0x00 and txResult to 0, and starts collection of the block. The first block byte is the opcode and the second is the argument.
- R5: At blkEnd, a block is well formed only when its opcode and byte count are one of these pairs: 0x01 with 1 or 2 bytes, 0x02 with 4, 0x03 with 36, 0x04 with 4. Any other opcode or count sets statusCode to 0x03, gives no execStart, and returns the device to ready.
- R6: A well-formed block with an opcode other than 0x01 pulses execStart for one cycle on the cycle after blkEnd, with execOp equal to the opcode. When execDone arrives, statusCode becomes 0x0F with txResult 0 if execFail is 1. Otherwise statusCode becomes 0x00 with txResult 1.
- R7: A well-formed pause block (opcode 0x01) makes paused 1 on the cycle after blkEnd in two cases: it has no argument, or the low 4 bits of its argument equal fuseAddr. Otherwise the device stays ready with statusCode 0x00.
- R8: While paused, wakeIn, flags, block bytes, blkEnd, execDone and token edges have no effect. Only watchdog expiry ends the pause, and it puts the device to sleep.
- R9: In the ready and block-collection states, TIMEOUT_CYC consecutive cycles without tokenEdge put the device to sleep. The timeout does not run in the idle, executing or paused states.
- R10: WATCHDOG_CYC cycles after wake the device is asleep, whatever its state. Watchdog expiry takes priority over any event in the same cycle, and that event changes no status.
- R11: A transmit flag pulses txStart for one cycle on the next cycle and leaves statusCode and txResult unchanged.
- R12: An idle flag sets idleMode. In idle, wakeIn returns the device to ready with statusCode and txResult preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeIn | input | 1 | Wake event from the line layer |
| tokenEdge | input | 1 | Leading edge of any token on the wire |
| flagValid | input | 1 | flagByte holds a complete flag |
| flagByte | input | 8 | Decoded flag value |
| blkByteValid | input | 1 | blkByte holds a command-block byte |
| blkByte | input | 8 | Command-block byte |
| blkEnd | input | 1 | End of the command block |
| execDone | input | 1 | Execution engine finished |
| execFail | input | 1 | Execution result is an error (qualified by execDone) |
| fuseAddr | input | 4 | Device address taken from four fuse bits |
| awake | output | 1 | Device not asleep |
| idleMode | output | 1 | Device parked in idle |
| paused | output | 1 | Device in address-selected pause |
| execStart | output | 1 | One-cycle start for the execution engine |
| execOp | output | 8 | Opcode of the current block |
| txStart | output | 1 | One-cycle request to turn the wire around and reply |
| txResult | output | 1 | Reply carries the command result rather than a status code |
| statusCode | output | 8 | Status byte for the reply |

## Verification
Watchdog expiry can land in the same cycle as a command flag. The bench keeps the timeout alive with a token edge on every cycle, then places a command flag exactly on the watchdog's last cycle. It expects sleep on the next cycle with statusCode still 0x11, which shows that the flag was never taken. The timeout can also meet a token edge: a reserved flag arrives on the last cycle of the quiet window, and the device must stay awake. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

  localparam int BLK_CNT_W = 6;
  localparam int BLK_CNT_MAX = (1 << BLK_CNT_W) - 1;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_READY,
    ST_IDLE,
    ST_RECV,
    ST_EXEC,
    ST_PAUSE
  } stateT;

  localparam logic [7:0] FLAG_CMD   = 8'h77;
  localparam logic [7:0] FLAG_TX    = 8'h88;
  localparam logic [7:0] FLAG_IDLE  = 8'hBB;
  localparam logic [7:0] FLAG_SLEEP = 8'hCC;

  localparam logic [7:0] OP_PAUSE  = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h02;
  localparam logic [7:0] OP_DIGEST = 8'h03;
  localparam logic [7:0] OP_BURN   = 8'h04;

  localparam logic [7:0] STAT_OK    = 8'h00;
  localparam logic [7:0] STAT_PARSE = 8'h03;
  localparam logic [7:0] STAT_EXEC  = 8'h0F;
  localparam logic [7:0] STAT_WAKE  = 8'h11;

  typedef struct packed {
    logic runTimeout;
    logic clrWdog;
    logic acceptByte;
    logic startBlk;
    logic setWake;
    logic setParse;
    logic setExec;
  } strobeT;

  function automatic logic lenFits(input logic [7:0] op, input logic [BLK_CNT_W-1:0] n);
    case (op)
      OP_PAUSE:  lenFits = (n == BLK_CNT_W'(1)) || (n == BLK_CNT_W'(2));
      OP_READ:   lenFits = (n == BLK_CNT_W'(4));
      OP_DIGEST: lenFits = (n == BLK_CNT_W'(36));
      OP_BURN:   lenFits = (n == BLK_CNT_W'(4));
      default:   lenFits = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
  import swfc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wakeIn,
  input  logic         flagValid,
  input  logic [7:0]   flagByte,
  input  logic         blkEnd,
  input  logic         execDone,
  input  logic         toHit,
  input  logic         wdHit,
  input  logic         lenOk,
  input  logic         isPause,
  input  logic         addrMatch,
  output strobeT       stb,
  output logic         awake,
  output logic         idleMode,
  output logic         paused,
  output logic         execStart,
  output logic         txStart
);

  stateT state, nextState;
  logic  execGo, txGo;

  always_comb begin
    nextState = state;
    stb = '0;
    execGo = 1'b0;
    txGo = 1'b0;
    stb.runTimeout = (state == ST_READY) || (state == ST_RECV);
    stb.clrWdog = (state == ST_SLEEP);
    stb.acceptByte = (state == ST_RECV);
    if (wdHit) begin
      nextState = ST_SLEEP;
    end else begin
      case (state)
        ST_SLEEP: begin
          if (wakeIn) begin
            nextState = ST_READY;
            stb.setWake = 1'b1;
          end
        end
        ST_IDLE: begin
          if (wakeIn) nextState = ST_READY;
        end
        ST_READY: begin
          if (toHit) begin
            nextState = ST_SLEEP;
          end else if (flagValid) begin
            case (flagByte)
              FLAG_CMD: begin
                nextState = ST_RECV;
                stb.startBlk = 1'b1;
              end
              FLAG_TX:    txGo = 1'b1;
              FLAG_IDLE:  nextState = ST_IDLE;
              FLAG_SLEEP: nextState = ST_SLEEP;
              default:    nextState = ST_READY;
            endcase
          end
        end
        ST_RECV: begin
          if (toHit) begin
            nextState = ST_SLEEP;
          end else if (blkEnd) begin
            if (!lenOk) begin
              nextState = ST_READY;
              stb.setParse = 1'b1;
            end else if (isPause) begin
              nextState = addrMatch ? ST_PAUSE : ST_READY;
            end else begin
              nextState = ST_EXEC;
              execGo = 1'b1;
            end
          end
        end
        ST_EXEC: begin
          if (execDone) begin
            nextState = ST_READY;
            stb.setExec = 1'b1;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_SLEEP;
      execStart <= 1'b0;
      txStart <= 1'b0;
    end else begin
      state <= nextState;
      execStart <= execGo;
      txStart <= txGo;
    end
  end

  assign awake = (state != ST_SLEEP);
  assign idleMode = (state == ST_IDLE);
  assign paused = (state == ST_PAUSE);

endmodule

// File: rtl/swfc_dpath.sv
module swfc_dpath
  import swfc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40,
  parameter int WATCHDOG_CYC = 2000
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       stb,
  input  logic         tokenEdge,
  input  logic         blkByteValid,
  input  logic [7:0]   blkByte,
  input  logic         execFail,
  input  logic [3:0]   fuseAddr,
  output logic         toHit,
  output logic         wdHit,
  output logic         lenOk,
  output logic         isPause,
  output logic         addrMatch,
  output logic [7:0]   execOp,
  output logic [7:0]   statusCode,
  output logic         resultValid
);

  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int WD_W = $clog2(WATCHDOG_CYC + 1);

  logic [TO_W-1:0]      toCnt;
  logic [WD_W-1:0]      wdCnt;
  logic [BLK_CNT_W-1:0] blkCnt;
  logic [7:0]           opReg;
  logic [3:0]           argNib;

  always_ff @(posedge clk) begin
    if (!rstN || !stb.runTimeout || tokenEdge) toCnt <= '0;
    else toCnt <= toCnt + 1'b1;
  end

  assign toHit = stb.runTimeout && !tokenEdge && (toCnt == TO_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrWdog) wdCnt <= '0;
    else wdCnt <= wdCnt + 1'b1;
  end

  assign wdHit = !stb.clrWdog && (wdCnt == WD_W'(WATCHDOG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkCnt <= '0;
      opReg <= '0;
      argNib <= '0;
    end else if (stb.startBlk) begin
      blkCnt <= '0;
    end else if (stb.acceptByte && blkByteValid) begin
      if (blkCnt == '0) opReg <= blkByte;
      if (blkCnt == BLK_CNT_W'(1)) argNib <= blkByte[3:0];
      if (blkCnt != BLK_CNT_W'(BLK_CNT_MAX)) blkCnt <= blkCnt + 1'b1;
    end
  end

  assign lenOk = lenFits(opReg, blkCnt);
  assign isPause = (opReg == OP_PAUSE);
  assign addrMatch = (blkCnt == BLK_CNT_W'(1)) || (argNib == fuseAddr);
  assign execOp = opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusCode <= STAT_OK;
      resultValid <= 1'b0;
    end else if (stb.setWake) begin
      statusCode <= STAT_WAKE;
      resultValid <= 1'b0;
    end else if (stb.startBlk) begin
      statusCode <= STAT_OK;
      resultValid <= 1'b0;
    end else if (stb.setParse) begin
      statusCode <= STAT_PARSE;
    end else if (stb.setExec) begin
      statusCode <= execFail ? STAT_EXEC : STAT_OK;
      resultValid <= !execFail;
    end
  end

endmodule

// File: rtl/swfc_top.sv
module swfc_top
  import swfc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40,
  parameter int WATCHDOG_CYC = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeIn,
  input  logic       tokenEdge,
  input  logic       flagValid,
  input  logic [7:0] flagByte,
  input  logic       blkByteValid,
  input  logic [7:0] blkByte,
  input  logic       blkEnd,
  input  logic       execDone,
  input  logic       execFail,
  input  logic [3:0] fuseAddr,
  output logic       awake,
  output logic       idleMode,
  output logic       paused,
  output logic       execStart,
  output logic [7:0] execOp,
  output logic       txStart,
  output logic       txResult,
  output logic [7:0] statusCode
);

  strobeT stb;
  logic   toHit, wdHit, lenOk, isPause, addrMatch;

  swfc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .flagValid(flagValid),
    .flagByte(flagByte), .blkEnd(blkEnd), .execDone(execDone),
    .toHit(toHit), .wdHit(wdHit), .lenOk(lenOk), .isPause(isPause),
    .addrMatch(addrMatch), .stb(stb), .awake(awake), .idleMode(idleMode),
    .paused(paused), .execStart(execStart), .txStart(txStart)
  );

  swfc_dpath #(.TIMEOUT_CYC(TIMEOUT_CYC), .WATCHDOG_CYC(WATCHDOG_CYC)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .tokenEdge(tokenEdge),
    .blkByteValid(blkByteValid), .blkByte(blkByte), .execFail(execFail),
    .fuseAddr(fuseAddr), .toHit(toHit), .wdHit(wdHit), .lenOk(lenOk),
    .isPause(isPause), .addrMatch(addrMatch), .execOp(execOp),
    .statusCode(statusCode), .resultValid(txResult)
  );

endmodule

// File: rtl/swfc_checker.sv
module swfc_checker #(
  parameter int WATCHDOG_CYC = 2000
) (
  input logic       clk,
  input logic       rstN,
  input logic       wakeIn,
  input logic       flagValid,
  input logic [7:0] flagByte,
  input logic       blkEnd,
  input logic       awake,
  input logic       paused,
  input logic       execStart,
  input logic       txStart,
  input logic [7:0] statusCode
);

  int awakeCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !awake) awakeCnt <= 0;
    else awakeCnt <= awakeCnt + 1;
  end

  p_wake_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awake) |-> $past(wakeIn));

  p_pause_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    paused |=> (paused || !awake));

  p_pause_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> $past(blkEnd));

  p_exec_after_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    execStart |-> ($past(blkEnd) && awake));

  p_tx_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(flagValid && (flagByte == 8'h88)));

  p_wdog_limit_r10: assert property (@(posedge clk) disable iff (!rstN)
    awake |-> (awakeCnt < WATCHDOG_CYC));

  p_status_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode == 8'h00) || (statusCode == 8'h03) ||
    (statusCode == 8'h0F) || (statusCode == 8'h11));

endmodule

bind swfc_top swfc_checker #(.WATCHDOG_CYC(WATCHDOG_CYC)) u_checker (
  .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .flagValid(flagValid),
  .flagByte(flagByte), .blkEnd(blkEnd), .awake(awake), .paused(paused),
  .execStart(execStart), .txStart(txStart), .statusCode(statusCode)
);

// File: tb/swfc_top_bench.sv
module swfc_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC = 12;
  localparam int WD_CYC = 400;
  localparam int MY_ADDR = 5;

  localparam int S_SLEEP = 0, S_READY = 1, S_IDLE = 2, S_RECV = 3, S_EXEC = 4, S_PAUSE = 5;

  logic clk = 0;
  logic rstN = 0;
  logic wakeIn = 0, tokenEdge = 0, flagValid = 0, blkByteValid = 0, blkEnd = 0;
  logic execDone = 0, execFail = 0;
  logic [7:0] flagByte = 0, blkByte = 0;
  logic [3:0] fuseAddr = 4'(MY_ADDR);
  logic awake, idleMode, paused, execStart, txStart, txResult;
  logic [7:0] execOp, statusCode;

  int checks = 0, errors = 0;
  bit finished = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  swfc_top #(.TIMEOUT_CYC(TO_CYC), .WATCHDOG_CYC(WD_CYC)) u_swfc_top (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .tokenEdge(tokenEdge),
    .flagValid(flagValid), .flagByte(flagByte), .blkByteValid(blkByteValid),
    .blkByte(blkByte), .blkEnd(blkEnd), .execDone(execDone), .execFail(execFail),
    .fuseAddr(fuseAddr), .awake(awake), .idleMode(idleMode), .paused(paused),
    .execStart(execStart), .execOp(execOp), .txStart(txStart),
    .txResult(txResult), .statusCode(statusCode)
  );

  // Behavioural reference model
  int mSt = S_SLEEP, mTo = 0, mWd = 0, mCnt = 0, mNext = 0;
  int mOp = 0, mArg = 0, mStat = 0;
  bit mRv = 0, mExec = 0, mTx = 0, mToHit = 0, mWdHit = 0;

  function automatic bit refLenGood(int op, int n);
    if (op == 1) return (n == 1) || (n == 2);
    if (op == 2 || op == 4) return n == 4;
    if (op == 3) return n == 36;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = S_SLEEP; mTo = 0; mWd = 0; mCnt = 0; mOp = 0; mArg = 0;
      mStat = 0; mRv = 0; mExec = 0; mTx = 0;
    end else begin
      mToHit = (mSt == S_READY || mSt == S_RECV) && !tokenEdge && (mTo == TO_CYC - 1);
      mWdHit = (mSt != S_SLEEP) && (mWd == WD_CYC - 1);
      mNext = mSt; mExec = 0; mTx = 0;
      if (mWdHit) mNext = S_SLEEP;
      else if (mSt == S_SLEEP) begin
        if (wakeIn) begin mNext = S_READY; mStat = 'h11; mRv = 0; end
      end else if (mSt == S_IDLE) begin
        if (wakeIn) mNext = S_READY;
      end else if (mSt == S_READY) begin
        if (mToHit) mNext = S_SLEEP;
        else if (flagValid) begin
          if (flagByte == 8'h77) begin mNext = S_RECV; mCnt = 0; mStat = 0; mRv = 0; end
          else if (flagByte == 8'h88) mTx = 1;
          else if (flagByte == 8'hBB) mNext = S_IDLE;
          else if (flagByte == 8'hCC) mNext = S_SLEEP;
        end
      end else if (mSt == S_RECV) begin
        if (mToHit) mNext = S_SLEEP;
        else if (blkEnd) begin
          if (!refLenGood(mOp, mCnt)) begin mNext = S_READY; mStat = 'h03; end
          else if (mOp == 1) mNext = (mCnt == 1 || (mArg % 16) == MY_ADDR) ? S_PAUSE : S_READY;
          else begin mNext = S_EXEC; mExec = 1; end
        end
      end else if (mSt == S_EXEC) begin
        if (execDone) begin
          mNext = S_READY; mStat = execFail ? 'h0F : 'h00; mRv = !execFail;
        end
      end
      if (mSt == S_SLEEP) mWd = 0; else mWd++;
      if (!(mSt == S_READY || mSt == S_RECV) || tokenEdge) mTo = 0; else mTo++;
      if (mSt == S_RECV && blkByteValid) begin
        if (mCnt == 0) mOp = blkByte;
        if (mCnt == 1) mArg = blkByte;
        if (mCnt < 63) mCnt++;
      end
      mSt = mNext;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(curReq, "awake", awake, mSt != S_SLEEP);
      check(curReq, "idleMode", idleMode, mSt == S_IDLE);
      check(curReq, "paused", paused, mSt == S_PAUSE);
      check(curReq, "execStart", execStart, mExec);
      check(curReq, "txStart", txStart, mTx);
      check(curReq, "txResult", txResult, mRv);
      check(curReq, "statusCode", statusCode, mStat);
      if (execStart && mExec) check(curReq, "execOp", execOp, mOp);
    end
  end

  task automatic sendFlag(input logic [7:0] f);
    @(negedge clk); flagValid = 1; flagByte = f; tokenEdge = 1;
    @(negedge clk); flagValid = 0; tokenEdge = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); blkByteValid = 1; blkByte = b; tokenEdge = 1;
    @(negedge clk); blkByteValid = 0; tokenEdge = 0;
  endtask

  task automatic endBlock();
    @(negedge clk); blkEnd = 1;
    @(negedge clk); blkEnd = 0;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeIn = 1; tokenEdge = 1;
    @(negedge clk); wakeIn = 0; tokenEdge = 0;
  endtask

  task automatic finishExec(input logic fail);
    repeat (3) @(negedge clk);
    execDone = 1; execFail = fail;
    @(negedge clk); execDone = 0; execFail = 0;
  endtask

  task automatic rewake();
    sendFlag(8'hCC);
    pulseWake();
  endtask

  task automatic sendBlock(input logic [7:0] op, input int n, input logic [7:0] arg);
    sendFlag(8'h77);
    for (int i = 0; i < n; i++) sendByte(i == 0 ? op : (i == 1 ? arg : 8'(i)));
    endBlock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "awake in reset", awake, 0);
    check("R1", "statusCode in reset", statusCode, 0);
    check("R1", "paused in reset", paused, 0);
    rstN = 1;
    @(negedge clk);
    check("R1", "execStart after reset", execStart, 0);

    curReq = "R2"; pulseWake();
    check("R2", "awake after wake", awake, 1);
    check("R2", "wake status", statusCode, 'h11);

    curReq = "R3"; sendFlag(8'h55); sendFlag(8'h00);
    check("R3", "reserved flag keeps status", statusCode, 'h11);

    curReq = "R11"; sendFlag(8'h88);
    check("R11", "status after transmit", statusCode, 'h11);

    curReq = "R6"; sendBlock(8'h02, 4, 8'h10); finishExec(0);
    check("R6", "status after good exec", statusCode, 0);
    check("R6", "result flag after good exec", txResult, 1);
    curReq = "R11"; sendFlag(8'h88);

    curReq = "R4"; sendFlag(8'h77);
    check("R4", "status cleared by command flag", statusCode, 0);
    check("R4", "result cleared by command flag", txResult, 0);
    curReq = "R5"; sendByte(8'h02); sendByte(8'h00); sendByte(8'h00); endBlock();
    check("R5", "short block status", statusCode, 'h03);

    rewake();
    curReq = "R5"; sendBlock(8'h09, 4, 8'h00);
    check("R5", "unknown opcode status", statusCode, 'h03);
    curReq = "R6"; sendBlock(8'h04, 4, 8'h00); finishExec(1);
    check("R6", "exec fail status", statusCode, 'h0F);
    sendBlock(8'h03, 36, 8'h00); finishExec(0);

    rewake();
    curReq = "R9"; repeat (TO_CYC - 2) @(negedge clk);
    sendFlag(8'h5A);
    check("R9", "token on last quiet cycle keeps awake", awake, 1);
    repeat (TO_CYC + 2) @(negedge clk);
    check("R9", "quiet wire sleeps", awake, 0);

    pulseWake();
    curReq = "R12"; sendFlag(8'h88); sendFlag(8'hBB);
    check("R12", "idle entered", idleMode, 1);
    repeat (TO_CYC + 5) @(negedge clk);
    sendFlag(8'h77);
    check("R12", "idle ignores timeout and flags", idleMode, 1);
    pulseWake();
    check("R12", "idle wake keeps status", statusCode, 'h11);

    curReq = "R7"; sendBlock(8'h01, 2, 8'h03);
    check("R7", "mismatched pause stays ready", paused, 0);
    sendBlock(8'h01, 2, 8'h15);
    check("R7", "matched pause", paused, 1);
    curReq = "R8"; pulseWake(); sendFlag(8'hCC); sendBlock(8'h02, 4, 8'h00);
    check("R8", "pause ignores traffic", paused, 1);
    while (awake) @(negedge clk);
    check("R8", "pause ends in sleep", paused, 0);

    pulseWake();
    curReq = "R7"; sendBlock(8'h01, 1, 8'h00);
    check("R7", "unaddressed pause", paused, 1);
    while (awake) @(negedge clk);

    pulseWake();
    curReq = "R10";
    while (mWd != WD_CYC - 1) begin
      tokenEdge = 1; @(negedge clk);
    end
    flagValid = 1; flagByte = 8'h77;
    @(negedge clk); flagValid = 0; tokenEdge = 0;
    check("R10", "watchdog beats command flag", awake, 0);
    check("R10", "flag not taken on expiry", statusCode, 'h11);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: bench hung, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule